// File: doc/BRIEF.md
# Two-Plane Pixel Plot Writer

This block takes single-pixel plot commands for a 40-column by 7-row dot-matrix display. Each command carries an x coordinate, a y coordinate and a 2-bit colour. The block writes the colour into a 70-byte byte-wide framebuffer that holds two bitplanes. The framebuffer stores pixels column-major, with character cells interleaved. Column x falls in character cell `x div 5` and at position `x mod 5` inside that cell. The linear bit number of a pixel is `cell*7 + position*56 + y`. Bits are packed eight per byte, least significant bit first.

Both planes use the same byte and bit position. The second plane sits 35 bytes above the first. The two colour bits together give four intensity codes per pixel. For each plane the block reads the byte, replaces the one target bit and writes the byte back, using a single-port memory. Other bits of the byte are not changed.

Commands arrive on a valid/ready handshake. The block takes a new command only when it is idle. A command whose coordinates are off the panel is still taken, but it has no effect on memory.

Top module: `plot_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmdReady` is 1 and `memEn` is 0.
- R2: The plane-0 byte address is `idx >> 3` and the bit position inside the byte is `idx & 7`, where `idx = (x / 5) * 7 + (x % 5) * 56 + y`.
- R3: The plane-1 access uses address plane-0 address + 35 and the same bit position.
- R4: After a command is accepted with x ≤ 39 and y ≤ 6, the next four cycles carry, in order, a read of the plane-0 byte, a write to it, a read of the plane-1 byte and a write to it. `cmdReady` is 0 in those four cycles and 1 in the cycle after them.
- R5: Each write carries the byte read in the cycle before it, with only the target bit replaced. The other seven bits are unchanged. Read data comes back on `memRdata` one cycle after the read is issued.
- R6: The plane-0 target bit takes colour bit 0 and the plane-1 target bit takes colour bit 1.
- R7: A command with x > 39 or y > 6 is accepted in one cycle. It makes no memory access, and `cmdReady` stays 1.
- R8: Command inputs presented while the block is busy (`cmdReady` = 0) are ignored: they reach neither memory nor any later write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Plot command present |
| cmdReady | output | 1 | Block idle and able to take a command |
| cmdX | input | 6 | Column, 0 to 39 on panel |
| cmdY | input | 3 | Row, 0 to 6 on panel |
| cmdColor | input | 2 | Bit 0 to plane 0, bit 1 to plane 1 |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | 1 = write, 0 = read (valid with memEn) |
| memAddr | output | 7 | Byte address, 0 to 69 |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, one cycle after a read |

## Verification
The assertions assume that the memory returns the addressed byte on `memRdata` exactly one cycle after a read. They also assume `memRdata` is held during the following write cycle, so the write-data check compares against a settled byte. The bench memory model registers its read data and updates only on a read, so both assumptions hold. Random commands are drawn with coordinates slightly past both panel edges, which exercises the drop path as well. One directed case keeps `cmdValid` high with changed coordinates throughout a busy window.

// File: rtl/plot_pkg.sv
package plot_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture the command into the datapath
    logic rd;     // issue a memory read
    logic wr;     // issue a memory write
    logic selB;   // current access targets plane 1
  } plot_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD_A = 3'd1,
    ST_WR_A = 3'd2,
    ST_RD_B = 3'd3,
    ST_WR_B = 3'd4
  } plot_state_e;

endpackage

// File: rtl/plot_addr_map.sv
module plot_addr_map #(
  parameter int COLS   = 40,
  parameter int ROWS   = 7,
  parameter int CELL_W = 5
) (
  input  logic [$clog2(COLS)-1:0]                   x,
  input  logic [$clog2(ROWS)-1:0]                   y,
  output logic                                      inRange,
  output logic [$clog2(2*((COLS*ROWS+7)/8))-1:0]    byteAddr,
  output logic [2:0]                                bitPos
);
  localparam int X_W       = $clog2(COLS);
  localparam int Y_W       = $clog2(ROWS);
  localparam int NUM_CELLS = COLS / CELL_W;
  localparam int CELL_BITS = $clog2(NUM_CELLS + 1);
  localparam int IDX_W     = $clog2(COLS * ROWS);
  localparam int ADDR_W    = $clog2(2 * ((COLS * ROWS + 7) / 8));
  localparam int STRIDE    = NUM_CELLS * ROWS;

  logic [CELL_BITS-1:0] cellIdx;
  logic [X_W-1:0]       colInCell;
  logic [IDX_W-1:0]     linIdx;

  // Divide and modulo by the cell width through a threshold compare chain
  always_comb begin
    cellIdx = '0;
    for (int k = 1; k < NUM_CELLS; k++) begin
      if (x >= X_W'(k * CELL_W)) cellIdx = cellIdx + 1'b1;
    end
    colInCell = x - X_W'(X_W'(cellIdx) * X_W'(CELL_W));
  end

  always_comb begin
    linIdx   = IDX_W'(IDX_W'(cellIdx) * IDX_W'(ROWS))
             + IDX_W'(IDX_W'(colInCell) * IDX_W'(STRIDE))
             + IDX_W'(y);
    byteAddr = ADDR_W'(linIdx >> 3);
    bitPos   = linIdx[2:0];
    inRange  = (x <= X_W'(COLS - 1)) && (y <= Y_W'(ROWS - 1));
  end

endmodule

// File: rtl/plot_ctrl.sv
module plot_ctrl
  import plot_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         coordOk,
  output logic         cmdReady,
  output plot_strobe_t strobe
);
  plot_state_e state, stateNext;
  logic accept;

  assign cmdReady = (state == ST_IDLE);
  assign accept   = cmdValid && cmdReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept && coordOk) stateNext = ST_RD_A;
      ST_RD_A: stateNext = ST_WR_A;
      ST_WR_A: stateNext = ST_RD_B;
      ST_RD_B: stateNext = ST_WR_B;
      ST_WR_B: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.load = accept && coordOk;
    strobe.rd   = (state == ST_RD_A) || (state == ST_RD_B);
    strobe.wr   = (state == ST_WR_A) || (state == ST_WR_B);
    strobe.selB = (state == ST_RD_B) || (state == ST_WR_B);
  end

  // R4: an accepted in-range command starts with a plane-0 read
  p_start_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && coordOk) |=> (strobe.rd && !strobe.selB && !cmdReady));

  // R4: after the last write the block is ready again
  p_ready_after_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr && strobe.selB) |=> cmdReady);

  // R4: each read is followed by a write in the same plane
  p_read_then_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rd |=> (strobe.wr && (strobe.selB == $past(strobe.selB))));

  // R7: an out-of-range command leaves the block idle with no access
  p_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !coordOk) |=> (cmdReady && !strobe.rd && !strobe.wr));

endmodule

// File: rtl/plot_datapath.sv
module plot_datapath
  import plot_pkg::*;
#(
  parameter int COLS   = 40,
  parameter int ROWS   = 7,
  parameter int CELL_W = 5
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  plot_strobe_t                            strobe,
  input  logic [$clog2(COLS)-1:0]                 cmdX,
  input  logic [$clog2(ROWS)-1:0]                 cmdY,
  input  logic [1:0]                              cmdColor,
  output logic                                    coordOk,
  output logic                                    memEn,
  output logic                                    memWe,
  output logic [$clog2(2*((COLS*ROWS+7)/8))-1:0]  memAddr,
  output logic [7:0]                              memWdata,
  input  logic [7:0]                              memRdata
);
  localparam int PLANE_BYTES = (COLS * ROWS + 7) / 8;
  localparam int ADDR_W      = $clog2(2 * PLANE_BYTES);

  logic [ADDR_W-1:0] mapAddr, baseAddr;
  logic [2:0]        mapBit, bitPosR;
  logic [1:0]        colorR;
  logic [7:0]        bitMask;
  logic              newBit;

  plot_addr_map #(.COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W)) i_map (
    .x        (cmdX),
    .y        (cmdY),
    .inRange  (coordOk),
    .byteAddr (mapAddr),
    .bitPos   (mapBit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      bitPosR  <= '0;
      colorR   <= '0;
    end else if (strobe.load) begin
      baseAddr <= mapAddr;
      bitPosR  <= mapBit;
      colorR   <= cmdColor;
    end
  end

  always_comb begin
    bitMask  = 8'd1 << bitPosR;
    newBit   = strobe.selB ? colorR[1] : colorR[0];
    memAddr  = strobe.selB ? baseAddr + ADDR_W'(PLANE_BYTES) : baseAddr;
    memWdata = (memRdata & ~bitMask) | (newBit ? bitMask : 8'd0);
    memEn    = strobe.rd || strobe.wr;
    memWe    = strobe.wr;
  end

  // R2: every access lands inside the two planes
  p_addr_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> (memAddr < ADDR_W'(2 * PLANE_BYTES)));

  // R2: an accepted pixel maps into plane 0
  p_map_plane0_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (mapAddr < ADDR_W'(PLANE_BYTES)));

  // R3: the plane-1 read sits one plane above the plane-0 write
  p_plane_offset_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr && !strobe.selB) |=> (memAddr == $past(memAddr) + ADDR_W'(PLANE_BYTES)));

  // R5: a write goes to the byte read in the cycle before
  p_rmw_same_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> (memWe && memAddr == $past(memAddr)));

  // R5: a write changes at most one bit of the byte read
  p_one_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($countones(memWdata ^ memRdata) <= 1));

endmodule

// File: rtl/plot_writer.sv
module plot_writer
  import plot_pkg::*;
#(
  parameter int COLS   = 40,
  parameter int ROWS   = 7,
  parameter int CELL_W = 5
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    cmdValid,
  output logic                                    cmdReady,
  input  logic [$clog2(COLS)-1:0]                 cmdX,
  input  logic [$clog2(ROWS)-1:0]                 cmdY,
  input  logic [1:0]                              cmdColor,
  output logic                                    memEn,
  output logic                                    memWe,
  output logic [$clog2(2*((COLS*ROWS+7)/8))-1:0]  memAddr,
  output logic [7:0]                              memWdata,
  input  logic [7:0]                              memRdata
);
  plot_strobe_t strobe;
  logic         coordOk;

  plot_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .coordOk  (coordOk),
    .cmdReady (cmdReady),
    .strobe   (strobe)
  );

  plot_datapath #(.COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdX     (cmdX),
    .cmdY     (cmdY),
    .cmdColor (cmdColor),
    .coordOk  (coordOk),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata)
  );

  // R1: no memory access while reset is held
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rstN |=> (!memEn && cmdReady));

endmodule

// File: tb/test_plot_writer.sv
module test_plot_writer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdReady;
  logic [5:0] cmdX = '0;
  logic [2:0] cmdY = '0;
  logic [1:0] cmdColor = '0;
  logic       memEn, memWe;
  logic [6:0] memAddr;
  logic [7:0] memWdata;
  logic [7:0] memRdata = '0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [7:0] mem    [0:69];
  logic [7:0] expMem [0:69];
  int         nOps = 0;
  int         opAddr [0:7];
  logic       opWe   [0:7];

  always #10 clk = ~clk;

  plot_writer i_plot_writer (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdX(cmdX), .cmdY(cmdY), .cmdColor(cmdColor),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // Memory model: read data one cycle after the read (R5 interface)
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr] <= memWdata;
      else       memRdata     <= mem[memAddr];
    end
  end

  // Access log
  always @(posedge clk) begin
    if (rstN && memEn) begin
      if (nOps < 8) begin
        opAddr[nOps] = int'(memAddr);
        opWe[nOps]   = memWe;
      end
      nOps = nOps + 1;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected < 100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int pixIndex(int x, int y);
    return (x / 5) * 7 + (x % 5) * 56 + y;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void modelPlot(int x, int y, int c);
    int idx, a, b;
    idx = pixIndex(x, y);
    a = idx >> 3;
    b = idx & 7;
    expMem[a][b]      = c[0];
    expMem[a + 35][b] = c[1];
  endfunction

  task automatic compareMem(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 70; i++) begin
      if (mem[i] !== expMem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, int'(mem[first]), int'(expMem[first]));
  endtask

  // One command; checks ready timing, access order and memory contents
  task automatic doPlot(input int x, input int y, input int c);
    bit inR;
    bit busyOk;
    int a, b;
    inR = (x <= 39) && (y <= 6);
    @(negedge clk);
    cmdX = 6'(x); cmdY = 3'(y); cmdColor = 2'(c); cmdValid = 1'b1;
    nOps = 0;
    @(negedge clk);
    cmdValid = 1'b0;
    busyOk = 1'b1;
    if (inR) begin
      for (int k = 0; k < 4; k++) begin
        if (cmdReady !== 1'b0) busyOk = 1'b0;
        @(negedge clk);
      end
      check(busyOk && cmdReady === 1'b1, "R4 ready low for four cycles", int'(cmdReady), 1);
      a = pixIndex(x, y) >> 3;
      b = pixIndex(x, y) & 7;
      check(nOps == 4, "R4 access count", nOps, 4);
      check(opAddr[0] == a && opWe[0] == 1'b0 && opAddr[1] == a && opWe[1] == 1'b1,
            "R2 plane-0 read/write address", opAddr[0], a);
      check(opAddr[2] == a + 35 && opWe[2] == 1'b0 && opAddr[3] == a + 35 && opWe[3] == 1'b1,
            "R3 plane-1 read/write address", opAddr[2], a + 35);
      modelPlot(x, y, c);
      compareMem("R5 R6 framebuffer contents");
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (cmdReady !== 1'b1) busyOk = 1'b0;
        @(negedge clk);
      end
      check(busyOk, "R7 ready stays high on drop", int'(cmdReady), 1);
      check(nOps == 0, "R7 no access on drop", nOps, 0);
      compareMem("R7 framebuffer untouched");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 70; i++) begin
      mem[i]    = 8'($urandom);
      expMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(cmdReady === 1'b1 && memEn === 1'b0, "R1 state in reset", int'(memEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady === 1'b1 && memEn === 1'b0, "R1 state after reset", int'(cmdReady), 1);

    // Directed corners
    doPlot(0, 0, 3);
    doPlot(39, 6, 1);
    doPlot(4, 6, 2);
    doPlot(5, 0, 3);
    doPlot(0, 0, 0);
    doPlot(40, 0, 3);
    doPlot(0, 7, 3);
    doPlot(63, 7, 3);
    doPlot(39, 6, 2);

    // R6: single colour bits land in their own plane
    doPlot(12, 3, 1);
    check(expMem[(pixIndex(12, 3) >> 3) + 35][pixIndex(12, 3) & 7] == 1'b0 &&
          mem[(pixIndex(12, 3) >> 3) + 35][pixIndex(12, 3) & 7] == 1'b0,
          "R6 colour 1 clears plane 1", int'(mem[(pixIndex(12, 3) >> 3) + 35]), 0);

    // R8: inputs changed while busy are ignored
    @(negedge clk);
    cmdX = 6'd17; cmdY = 3'd2; cmdColor = 2'd3; cmdValid = 1'b1;
    @(negedge clk);
    cmdX = 6'd33; cmdY = 3'd5; cmdColor = 2'd0;
    repeat (3) @(negedge clk);
    cmdValid = 1'b0;
    repeat (2) @(negedge clk);
    modelPlot(17, 2, 3);
    compareMem("R8 busy inputs ignored");

    // Random commands, some off the panel
    for (int n = 0; n < 160; n++) begin
      doPlot(int'($urandom_range(45, 0)), int'($urandom_range(7, 0)),
             int'($urandom_range(3, 0)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule